// File: doc/BRIEF.md
# Serial-Loaded Dual-Channel DAC Register File

This block takes 16-bit command words from a write-only 3-wire serial link (active-low select, serial clock, data in). It decodes each word and updates two 10-bit channels, A and B. Each channel has two stages: a staging (input) register and a live (DAC) register. The live values drive the converter. The block also gives a separate power controller a one-cycle command strobe, one-cycle mode-request pulses, and a held 2-bit reference selection.

The serial pins are asynchronous to the system clock. Each pin passes through a parameterised synchronizer, and edges are found by comparing the synchronized value with its value one cycle earlier. The receiver is a three-state machine:
- `ST_IDLE` waits for select to fall, clears the bit counter and moves to `ST_SHIFT`.
- `ST_SHIFT` shifts in one bit on every rising serial-clock edge, with the counter saturating. When select rises, it goes to `ST_EXEC` if exactly 16 bits arrived, and back to `ST_IDLE` otherwise.
- `ST_EXEC` lasts one cycle, presents the frame to the decoder, and returns to `ST_IDLE`.

The registers, the strobe and the mode pulses update on the clock edge that ends `ST_EXEC`.

Top module: `dacsr_top`

## Requirements
- R1: A frame carries the opcode in its first 4 bits, then a 10-bit code sent MSB first, then 2 trailing bits. Bits are captured on rising edges of `sclk` while `cs_n` is low, so the code sits in frame bits 11..2 and the opcode in bits 15..12.
- R2: A frame executes when `cs_n` rises, and only if exactly 16 rising `sclk` edges were seen while `cs_n` was low. A frame of 15 or 17 bits changes no register and gives no strobe.
- R3: Opcode 0001 writes the code into staging A, and opcode 0010 writes it into staging B. Neither changes `dac_a` or `dac_b`.
- R4: Opcode 1000 copies both staging registers into both live registers in the same cycle.
- R5: Opcode 1001 writes the code into staging A and live A and copies staging B into live B. Opcode 1010 writes the code into staging B and live B and copies staging A into live A.
- R6: Opcode 1111 writes the code into all four registers.
- R7: Opcode 0000 and the reserved opcodes 0011 to 0111 and 1011 leave all four registers unchanged.
- R8: `cmd_strobe` is high for exactly one cycle for each executed 16-bit frame, whatever its opcode. It rises in the same cycle that the register updates become visible.
- R9: Opcode 1100 pulses `req_standby`, 1110 pulses `req_shutdown`, and 1101 pulses `req_normal`. Opcodes 1000, 1001, 1010 and 1111 also pulse `req_normal`. At most one request is high at a time, and each request pulses together with `cmd_strobe`.
- R10: On opcodes 1100, 1101 and 1110, `ref_sel` takes code bits 9..8. Other opcodes leave it unchanged.
- R11: Reset clears all four registers, `ref_sel` and every pulse output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| dac_a | output | 10 | Live register of channel A |
| dac_b | output | 10 | Live register of channel B |
| cmd_strobe | output | 1 | One-cycle pulse per executed frame |
| req_standby | output | 1 | Standby request pulse |
| req_normal | output | 1 | Normal-operation request pulse |
| req_shutdown | output | 1 | Shutdown request pulse |
| ref_sel | output | 2 | Held reference selection |

## Verification
On every cycle, the assertions check four things. `ST_EXEC` follows only a full 16-bit count. A live register holds unless a load or copy is decoded. A copy lands the old staging value. The request pulses are one-hot, single-cycle and aligned with the strobe. The bench scenarios are the only way to show the rest: the bit order within a frame, which channel each opcode touches, and the discarding of short and long frames. They also show that reserved opcodes leave the hidden staging registers intact, which becomes visible only through a later transfer to the live registers.

// File: rtl/dacsr_pkg.sv
package dacsr_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CODE_BITS  = 10;
    localparam int OP_BITS    = 4;

    typedef enum logic [3:0] {
        OP_NOP    = 4'h0,
        OP_LD_A   = 4'h1,
        OP_LD_B   = 4'h2,
        OP_XFER   = 4'h8,
        OP_LDX_A  = 4'h9,
        OP_LDX_B  = 4'hA,
        OP_STBY   = 4'hC,
        OP_WAKE   = 4'hD,
        OP_SHDN   = 4'hE,
        OP_LD_ALL = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EXEC  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [1:0] ld_in;
        logic [1:0] ld_dac;
        logic [1:0] xfer;
        logic       req_stby;
        logic       req_norm;
        logic       req_shdn;
        logic       ref_wr;
    } action_t;

endpackage

// File: rtl/dacsr_sync.sv
module dacsr_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacsr_serial_rx.sv
module dacsr_serial_rx
    import dacsr_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               sdi_s,
    output logic               frame_valid,
    output logic [FRAME_W-1:0] frame
);
    localparam int               CNT_W    = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    rx_state_e          state, state_nx;
    logic               sclk_d, cs_d;
    logic               sclk_rise, cs_fall, cs_rise;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_fall   = ~cs_n_s & cs_d;
    assign cs_rise   = cs_n_s & ~cs_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT: if (cs_rise) state_nx = (bit_cnt == FULL_CNT) ? ST_EXEC : ST_IDLE;
            ST_EXEC:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            if (state == ST_IDLE && cs_fall) begin
                bit_cnt <= '0;
            end else if (state == ST_SHIFT && sclk_rise && !cs_rise) begin
                shreg <= {shreg[FRAME_W-2:0], sdi_s};
                if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        frame_valid = (state == ST_EXEC);
        frame       = shreg;
    end

    // R2: execution only follows a select rise seen with a full count
    a_r2_exec_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |-> ($past(state) == ST_SHIFT && $past(bit_cnt) == FULL_CNT));

    // R2: execution never lasts more than one cycle
    a_r2_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |=> (state == ST_IDLE));

    // R1: no bit is counted while the select is idle
    a_r1_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cs_fall) |=> $stable(bit_cnt));
endmodule

// File: rtl/dacsr_cmd_decode.sv
module dacsr_cmd_decode
    import dacsr_pkg::*;
(
    input  logic [OP_BITS-1:0] op,
    output action_t            act
);
    always_comb begin
        act = '0;
        unique case (op)
            OP_LD_A:   act.ld_in = 2'b01;
            OP_LD_B:   act.ld_in = 2'b10;
            OP_XFER: begin
                act.xfer     = 2'b11;
                act.req_norm = 1'b1;
            end
            OP_LDX_A: begin
                act.ld_in    = 2'b01;
                act.ld_dac   = 2'b01;
                act.xfer     = 2'b10;
                act.req_norm = 1'b1;
            end
            OP_LDX_B: begin
                act.ld_in    = 2'b10;
                act.ld_dac   = 2'b10;
                act.xfer     = 2'b01;
                act.req_norm = 1'b1;
            end
            OP_STBY: begin
                act.req_stby = 1'b1;
                act.ref_wr   = 1'b1;
            end
            OP_WAKE: begin
                act.req_norm = 1'b1;
                act.ref_wr   = 1'b1;
            end
            OP_SHDN: begin
                act.req_shdn = 1'b1;
                act.ref_wr   = 1'b1;
            end
            OP_LD_ALL: begin
                act.ld_in    = 2'b11;
                act.ld_dac   = 2'b11;
                act.req_norm = 1'b1;
            end
            default: act = '0;   // no-op and reserved codes
        endcase
    end
endmodule

// File: rtl/dacsr_chan_regs.sv
module dacsr_chan_regs #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         ld_in,
    input  logic         ld_dac,
    input  logic         xfer,
    input  logic [W-1:0] data,
    output logic [W-1:0] in_q,
    output logic [W-1:0] dac_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            dac_q <= '0;
        end else if (en) begin
            if (ld_in)       in_q  <= data;
            if (ld_dac)      dac_q <= data;
            else if (xfer)   dac_q <= in_q;
        end
    end

    // R3/R7: live register holds without a load or copy
    a_r3_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && (ld_dac || xfer)) |=> $stable(dac_q));

    // R4: a copy lands the staging value held before the edge
    a_r4_xfer_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (en && xfer && !ld_dac) |=> (dac_q == $past(in_q)));

    // R7: staging register holds without a load
    a_r7_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && ld_in) |=> $stable(in_q));
endmodule

// File: rtl/dacsr_top.sv
module dacsr_top
    import dacsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CH      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    output logic [CODE_BITS-1:0] dac_a,
    output logic [CODE_BITS-1:0] dac_b,
    output logic                 cmd_strobe,
    output logic                 req_standby,
    output logic                 req_normal,
    output logic                 req_shutdown,
    output logic [1:0]           ref_sel
);
    localparam int OP_LSB   = FRAME_BITS - OP_BITS;
    localparam int CODE_LSB = OP_LSB - CODE_BITS;

    logic                  cs_n_s, sclk_s, sdi_s;
    logic                  frame_valid;
    logic [FRAME_BITS-1:0] frame;
    logic [OP_BITS-1:0]    op;
    logic [CODE_BITS-1:0]  code;
    action_t               act;
    logic [CODE_BITS-1:0]  in_q  [NUM_CH];
    logic [CODE_BITS-1:0]  dac_q [NUM_CH];

    dacsr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi}),
        .q     ({cs_n_s, sclk_s, sdi_s})
    );

    dacsr_serial_rx #(.FRAME_W(FRAME_BITS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (cs_n_s),
        .sclk_s      (sclk_s),
        .sdi_s       (sdi_s),
        .frame_valid (frame_valid),
        .frame       (frame)
    );

    assign op   = frame[FRAME_BITS-1:OP_LSB];
    assign code = frame[OP_LSB-1:CODE_LSB];

    dacsr_cmd_decode u_dec (
        .op  (op),
        .act (act)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dacsr_chan_regs #(.W(CODE_BITS)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (frame_valid),
            .ld_in  (act.ld_in[ch]),
            .ld_dac (act.ld_dac[ch]),
            .xfer   (act.xfer[ch]),
            .data   (code),
            .in_q   (in_q[ch]),
            .dac_q  (dac_q[ch])
        );
    end

    assign dac_a = dac_q[0];
    assign dac_b = dac_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_strobe   <= 1'b0;
            req_standby  <= 1'b0;
            req_normal   <= 1'b0;
            req_shutdown <= 1'b0;
            ref_sel      <= 2'b00;
        end else begin
            cmd_strobe   <= frame_valid;
            req_standby  <= frame_valid & act.req_stby;
            req_normal   <= frame_valid & act.req_norm;
            req_shutdown <= frame_valid & act.req_shdn;
            if (frame_valid && act.ref_wr) ref_sel <= code[CODE_BITS-1:CODE_BITS-2];
        end
    end

    // R9: requests are mutually exclusive
    a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_standby, req_normal, req_shutdown}));

    // R9: every request coincides with the strobe
    a_r9_req_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_standby || req_normal || req_shutdown) |-> cmd_strobe);

    // R8: the strobe is a single-cycle pulse
    a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    // R10: the reference selection moves only with a strobe
    a_r10_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |-> $stable(ref_sel));
endmodule

// File: tb/dacsr_top_tb.sv
module dacsr_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 3;

    typedef struct {
        string      tag;
        logic [9:0] da;
        logic [9:0] db;
        logic [1:0] rs;
        int         n_strobe;
        int         n_stby;
        int         n_norm;
        int         n_shdn;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [9:0] dac_a, dac_b;
    logic       cmd_strobe, req_standby, req_normal, req_shutdown;
    logic [1:0] ref_sel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int cnt_strobe = 0, cnt_stby = 0, cnt_norm = 0, cnt_shdn = 0;

    item_t sb_q[$];
    event  ev_frame;

    // reference model state
    logic [9:0] m_ina = '0, m_inb = '0, m_da = '0, m_db = '0;
    logic [1:0] m_rs = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacsr_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .sdi          (sdi),
        .dac_a        (dac_a),
        .dac_b        (dac_b),
        .cmd_strobe   (cmd_strobe),
        .req_standby  (req_standby),
        .req_normal   (req_normal),
        .req_shutdown (req_shutdown),
        .ref_sel      (ref_sel)
    );

    always @(posedge clk) begin
        if (cmd_strobe)   cnt_strobe++;
        if (req_standby)  cnt_stby++;
        if (req_normal)   cnt_norm++;
        if (req_shutdown) cnt_shdn++;
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares outputs and pulse counts
    initial begin
        int p_str = 0, p_sb = 0, p_nm = 0, p_sd = 0;
        item_t it;
        forever begin
            @(ev_frame);
            it = sb_q.pop_front();
            chk(it.tag, "dac_a",   int'(dac_a),   int'(it.da));
            chk(it.tag, "dac_b",   int'(dac_b),   int'(it.db));
            chk(it.tag, "ref_sel", int'(ref_sel), int'(it.rs));
            chk(it.tag, "strobes", cnt_strobe - p_str, it.n_strobe);
            chk(it.tag, "standby", cnt_stby - p_sb, it.n_stby);
            chk(it.tag, "normal",  cnt_norm - p_nm, it.n_norm);
            chk(it.tag, "shutdown",cnt_shdn - p_sd, it.n_shdn);
            p_str = cnt_strobe; p_sb = cnt_stby; p_nm = cnt_norm; p_sd = cnt_shdn;
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: shifts nbits of bits (MSB first), updates the model, queues the expectation
    task automatic send(input string tag, input logic [3:0] op, input logic [9:0] code, input int nbits);
        logic [31:0] bits;
        item_t it;
        int st = 0, sb = 0, nm = 0, sd = 0;
        logic [15:0] word = {op, code, 2'b00};
        bits = (nbits == 17) ? {15'd0, word, 1'b0} : (nbits == 15) ? {17'd0, word[15:1]} : {16'd0, word};
        wait_neg(1);
        cs_n = 1'b0;
        wait_neg(HALF_SCK);
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[nbits-1-i];
            wait_neg(HALF_SCK);
            sclk = 1'b1;
            wait_neg(HALF_SCK);
            sclk = 1'b0;
        end
        wait_neg(HALF_SCK);
        cs_n = 1'b1;
        if (nbits == 16) begin
            st = 1;
            case (op)
                4'h1: m_ina = code;
                4'h2: m_inb = code;
                4'h8: begin m_da = m_ina; m_db = m_inb; nm = 1; end
                4'h9: begin m_ina = code; m_da = code; m_db = m_inb; nm = 1; end
                4'hA: begin m_inb = code; m_db = code; m_da = m_ina; nm = 1; end
                4'hC: begin m_rs = code[9:8]; sb = 1; end
                4'hD: begin m_rs = code[9:8]; nm = 1; end
                4'hE: begin m_rs = code[9:8]; sd = 1; end
                4'hF: begin m_ina = code; m_inb = code; m_da = code; m_db = code; nm = 1; end
                default: ;
            endcase
        end
        it.tag = tag; it.da = m_da; it.db = m_db; it.rs = m_rs;
        it.n_strobe = st; it.n_stby = sb; it.n_norm = nm; it.n_shdn = sd;
        sb_q.push_back(it);
        wait_neg(12);
        ->ev_frame;
        wait_neg(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(2);
        // R11: reset state
        chk("R11", "dac_a",      int'(dac_a), 0);
        chk("R11", "dac_b",      int'(dac_b), 0);
        chk("R11", "ref_sel",    int'(ref_sel), 0);
        chk("R11", "cmd_strobe", int'(cmd_strobe), 0);
        chk("R11", "requests",   int'({req_standby, req_normal, req_shutdown}), 0);

        // R3 / R1: staging loads, live registers untouched
        send("R3",  4'h1, 10'h2A5, 16);
        send("R3",  4'h2, 10'h15A, 16);
        // R4 / R1: simultaneous transfer exposes bit order of both loads
        send("R4",  4'h8, 10'h000, 16);
        // R5: mixed load and copy for each channel
        send("R3",  4'h2, 10'h0F0, 16);
        send("R5",  4'h9, 10'h3FF, 16);
        send("R5",  4'hA, 10'h001, 16);
        // R6: write all four
        send("R6",  4'hF, 10'h200, 16);
        // R7: no-op and reserved opcodes, then expose staging via transfer
        send("R3",  4'h1, 10'h123, 16);
        send("R7",  4'h0, 10'h3FF, 16);
        send("R7",  4'h3, 10'h3FF, 16);
        send("R7",  4'h7, 10'h155, 16);
        send("R7",  4'hB, 10'h0AA, 16);
        send("R7",  4'h8, 10'h000, 16);
        // R2: wrong bit counts are discarded
        send("R2",  4'hF, 10'h055, 15);
        send("R2",  4'hF, 10'h055, 17);
        send("R2",  4'h8, 10'h000, 16);
        // R9 / R10: mode requests and reference selection
        send("R9",  4'hC, 10'h2FF, 16);
        send("R10", 4'hE, 10'h300, 16);
        send("R9",  4'hD, 10'h100, 16);
        send("R10", 4'h1, 10'h3C0, 16);
        // R8: strobe counts checked on every frame above; final transfer
        send("R8",  4'h8, 10'h000, 16);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule